// File: doc/BRIEF.md
# UART transmitter with driver-enable control

This block is the transmit half of a UART meant for half-duplex, multi-drop links where a line transceiver must be switched into drive mode only while a node is talking. Software writes one character at a time into a single-entry holding register through a write strobe. The character then moves into a shift register and leaves on the serial line as a complete frame. A driver-enable output frames the transmission. It turns on one bit period before the start bit so the transceiver has time to settle. It stays on across characters that are queued in time. It turns off one system clock after the last stop bit ends.

A holding-register-empty flag and a one-cycle interrupt pulse tell software when the next character may be written. The flag rises as soon as the first data bit of the current character has left the line. This gives software most of a character time to supply the next one, so a run of characters goes out with no gap and no break in driver enable. The bit period, the parity mode, the number of stop bits and the active level of driver enable are static configuration inputs.

Top module: `uart_de_tx`

## Requirements
- R1: After reset, and whenever no character is pending or in flight, `txd` is 1, `de` sits at its inactive level, `tdre` is 1 and `tx_irq` is 0.
- R2: A frame consists of a start bit of 0 followed by the 8 data bits, least significant bit first. Each bit lasts `baud_div` clock cycles, and a `baud_div` of 0 acts as 1.
- R3: When `par_en` is 1, one parity bit follows bit 7. With `par_odd` at 0 the parity bit makes the count of ones over data and parity even. With `par_odd` at 1 it makes that count odd. When `par_en` is 0 no parity bit is sent.
- R4: The frame ends with one stop bit of 1 when `two_stop` is 0, and with two stop bits when it is 1.
- R5: On a write to an idle transmitter (`wr_en` high at clock edge E0), `de` becomes active after edge E0+1. The line then holds 1 for exactly one bit period before the start bit, which begins after edge E0+1+`baud_div`.
- R6: After the clock edge that ends the last stop bit, `de` stays active for one more clock cycle with `txd` at 1. It then returns to its inactive level.
- R7: If a character is written before the current frame's last stop bit ends, its start bit follows that stop bit directly, with no lead period. `de` stays active without a break across both frames.
- R8: `de` is active high when `de_pol` is 1 and active low when `de_pol` is 0.
- R9: `tdre` goes from 0 to 1 at the clock edge that ends data bit 0 of the character in the shift register. `tx_irq` is high for exactly that one cycle.
- R10: A write clears `tdre` to 0 from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to transmit |
| baud_div | input | 16 | Bit period in clock cycles |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| de_pol | input | 1 | 1 makes driver enable active high |
| txd | output | 1 | Serial data line, idle high |
| de | output | 1 | Transceiver driver enable |
| tdre | output | 1 | Holding register empty flag |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
The embedded properties rely on three things holding at the inputs. Software writes only while `tdre` is 1. The configuration inputs, `baud_div` in particular, stay constant while a frame is in flight. Reset is asserted before the first write. The directed bench changes the configuration only while the line is idle, after the driver-enable tail has completed. It issues its only mid-frame write after it has seen `tdre` return to 1. Bit values are sampled at the centre of each bit period, and the driver-enable edges, the flag and the interrupt pulse are checked on the exact clock they are due.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_START = 3'd2,
      ST_DATA  = 3'd3,
      ST_PAR   = 3'd4,
      ST_STOP  = 3'd5,
      ST_TAIL  = 3'd6
   } tx_state_e;

endpackage

// File: rtl/uatx_baud.sv
module uatx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   // a zero divisor behaves as a divisor of one
   assign lim  = (div == '0) ? '0 : div - 1'b1;
   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= lim));

endmodule

// File: rtl/uatx_hold.sv
module uatx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   input  logic              first_done,
   output logic [DATA_W-1:0] hold_q,
   output logic              pending,
   output logic              tdre,
   output logic              tx_irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         pending <= 1'b0;
         tdre    <= 1'b1;
         tx_irq  <= 1'b0;
      end else begin
         if (wr_en) begin
            hold_q <= wr_data;
         end
         if (wr_en) begin
            pending <= 1'b1;
         end else if (take) begin
            pending <= 1'b0;
         end
         if (wr_en) begin
            tdre <= 1'b0;
         end else if (first_done) begin
            tdre <= 1'b1;
         end
         tx_irq <= first_done && !wr_en;
      end
   end

   assert_write_clears_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tdre);

   assert_irq_on_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (tdre && !$past(tdre)));

endmodule

// File: rtl/uatx_seq.sv
module uatx_seq
   import uatx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pending,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   output logic              run,
   output logic              take,
   output logic              first_done,
   output logic              txd,
   output logic              de_act
);

   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   tx_state_e         state;
   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_idx;
   logic              par_bit;
   logic              stop_idx;
   logic              stop_last;
   logic              load_idle;
   logic              load_chain;

   assign stop_last  = !two_stop || stop_idx;
   assign load_idle  = (state == ST_IDLE) && pending;
   assign load_chain = (state == ST_STOP) && tick && stop_last && pending;
   assign take       = load_idle || load_chain;
   assign run        = (state != ST_IDLE) && (state != ST_TAIL);
   assign first_done = (state == ST_DATA) && tick && (bit_idx == '0);
   assign de_act     = (state != ST_IDLE);

   always_comb begin
      txd = 1'b1;
      case (state)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = shreg[0];
         ST_PAR:   txd = par_bit;
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         bit_idx  <= '0;
         par_bit  <= 1'b0;
         stop_idx <= 1'b0;
      end else begin
         if (take) begin
            shreg   <= hold_q;
            par_bit <= (^hold_q) ^ par_odd;
         end
         case (state)
            ST_IDLE: begin
               if (pending) begin
                  state <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  state <= ST_START;
               end
            end
            ST_START: begin
               if (tick) begin
                  state   <= ST_DATA;
                  bit_idx <= '0;
               end
            end
            ST_DATA: begin
               if (tick) begin
                  shreg <= {1'b0, shreg[DATA_W-1:1]};
                  if (bit_idx == LAST_BIT) begin
                     stop_idx <= 1'b0;
                     state    <= par_en ? ST_PAR : ST_STOP;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               if (tick) begin
                  stop_idx <= 1'b0;
                  state    <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (tick) begin
                  if (!stop_last) begin
                     stop_idx <= 1'b1;
                  end else if (pending) begin
                     state <= ST_START;
                  end else begin
                     state <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               state <= ST_IDLE;
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !de_act |-> txd);

   assert_de_drop_after_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(de_act) |-> ($past(state) == ST_TAIL));

   assert_start_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_START) && ($past(state) != ST_START))
         |-> (($past(state) == ST_LEAD) || ($past(state) == ST_STOP)));

   assert_lead_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de_act) |-> (state == ST_LEAD));

endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              de_pol,
   output logic              txd,
   output logic              de,
   output logic              tdre,
   output logic              tx_irq
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data_w
         $error("uart_de_tx: DATA_W must lie between 5 and 9");
      end
      if (DIV_W < 2) begin : g_bad_div_w
         $error("uart_de_tx: DIV_W must be at least 2");
      end
   endgenerate

   logic              tick;
   logic              run;
   logic              take;
   logic              first_done;
   logic              pending;
   logic              de_act;
   logic [DATA_W-1:0] hold_q;

   uatx_baud #(.DIV_W(DIV_W)) i_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (baud_div),
      .tick (tick)
   );

   uatx_hold #(.DATA_W(DATA_W)) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .take      (take),
      .first_done(first_done),
      .hold_q    (hold_q),
      .pending   (pending),
      .tdre      (tdre),
      .tx_irq    (tx_irq)
   );

   uatx_seq #(.DATA_W(DATA_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pending   (pending),
      .hold_q    (hold_q),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .two_stop  (two_stop),
      .run       (run),
      .take      (take),
      .first_done(first_done),
      .txd       (txd),
      .de_act    (de_act)
   );

   assign de = de_pol ? de_act : !de_act;

   assert_de_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!de_act) |-> (de == !de_pol));

endmodule

// File: tb/test_uart_de_tx.sv
module test_uart_de_tx;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [15:0] baud_div = 16'd4;
   logic        par_en = 1'b0;
   logic        par_odd = 1'b0;
   logic        two_stop = 1'b0;
   logic        de_pol = 1'b1;
   logic        txd;
   logic        de;
   logic        tdre;
   logic        tx_irq;

   int n_chk = 0;
   int n_fail = 0;
   int pos = 0;
   int sched_pos = -1;
   logic [7:0] sched_data = 8'h00;
   bit mon_de = 1'b0;
   int de_bad = 0;
   bit done = 1'b0;

   uart_de_tx i_uart_de_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .baud_div(baud_div),
      .par_en  (par_en),
      .par_odd (par_odd),
      .two_stop(two_stop),
      .de_pol  (de_pol),
      .txd     (txd),
      .de      (de),
      .tdre    (tdre),
      .tx_irq  (tx_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic lvl(input bit a);
      return de_pol ? a : !a;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at pos %0d: actual %0h expected %0h", req, what, pos, act, exp);
      end
   endtask

   task automatic adv();
      @(negedge clk);
      pos++;
      if (pos == sched_pos) begin
         wr_en   = 1'b1;
         wr_data = sched_data;
      end else begin
         wr_en = 1'b0;
      end
      if (pos == sched_pos + 1) begin
         chk("R10", "tdre after write", tdre, 1'b0);
         sched_pos = -1;
      end
      if (mon_de && de !== lvl(1'b1)) de_bad++;
   endtask

   task automatic goto(input int t);
      while (pos < t) adv();
   endtask

   // write into an idle transmitter; returns at the first cycle with de active
   task automatic start_write(input logic [7:0] d);
      @(negedge clk);
      pos        = 0;
      sched_pos  = 0;
      sched_data = d;
      wr_en      = 1'b1;
      wr_data    = d;
      adv();
      chk("R5", "de still inactive one cycle after write", de, lvl(1'b0));
      chk("R1", "txd idle before lead", txd, 1'b1);
      adv();
      chk("R5", "de active second cycle after write", de, lvl(1'b1));
   endtask

   task automatic frame(input logic [7:0] d, input bit lead, input int base,
                        input bit more, output int endp);
      int div;
      int sb;
      int ns;
      int tset;
      logic exp_b;
      string tag;
      div  = (baud_div == 0) ? 1 : int'(baud_div);
      sb   = lead ? 1 : 0;
      ns   = sb + 1 + 8 + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
      endp = base + ns * div;
      tset = base + (sb + 2) * div;
      mon_de = 1'b1;
      for (int j = 0; j < ns; j++) begin
         if (j == sb && lead) begin
            goto(base + div - 1);
            chk("R5", "line high at end of lead", txd, 1'b1);
            goto(base + div);
            chk("R5", "start bit right after lead", txd, 1'b0);
         end
         if (j == sb + 2) begin
            goto(tset - 1);
            chk("R9", "tdre low before bit0 ends", tdre, 1'b0);
            goto(tset);
            chk("R9", "tdre set at bit0 end", tdre, 1'b1);
            chk("R9", "irq pulse", tx_irq, 1'b1);
            goto(tset + 1);
            chk("R9", "irq single cycle", tx_irq, 1'b0);
         end
         goto(base + j * div + div / 2);
         if (j < sb) begin
            exp_b = 1'b1; tag = "R5";
         end else if (j == sb) begin
            exp_b = 1'b0; tag = "R2";
         end else if (j <= sb + 8) begin
            exp_b = d[j - sb - 1]; tag = "R2";
         end else if (par_en && j == sb + 9) begin
            exp_b = (^d) ^ par_odd; tag = "R3";
         end else begin
            exp_b = 1'b1; tag = "R4";
         end
         chk(tag, $sformatf("txd slot %0d", j), txd, exp_b);
      end
      if (!more) begin
         goto(endp - 1);
         chk("R4", "last stop still high", txd, 1'b1);
         goto(endp);
         chk("R6", "de held one clock after stop", de, lvl(1'b1));
         chk("R6", "txd high in tail", txd, 1'b1);
         mon_de = 1'b0;
         goto(endp + 1);
         chk("R6", "de released", de, lvl(1'b0));
         chk("R1", "txd idle after frame", txd, 1'b1);
         chk("R1", "tdre idle after frame", tdre, 1'b1);
      end
   endtask

   task automatic setup(input int div, input bit pe, input bit po,
                        input bit ts, input bit pol);
      @(negedge clk);
      baud_div = 16'(div);
      par_en   = pe;
      par_odd  = po;
      two_stop = ts;
      de_pol   = pol;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "txd after reset", txd, 1'b1);
      chk("R1", "de after reset", de, lvl(1'b0));
      chk("R1", "tdre after reset", tdre, 1'b1);
      chk("R1", "irq after reset", tx_irq, 1'b0);
      repeat (20) @(negedge clk);
      chk("R1", "txd idle hold", txd, 1'b1);
      chk("R1", "de idle hold", de, lvl(1'b0));
   endtask

   task automatic t_single(input logic [7:0] d, input int div, input bit pe,
                           input bit po, input bit ts, input bit pol);
      int e;
      setup(div, pe, po, ts, pol);
      chk("R8", "inactive level before frame", de, pol ? 1'b0 : 1'b1);
      de_bad = 0;
      start_write(d);
      chk("R8", "active level", de, pol ? 1'b1 : 1'b0);
      frame(d, 1'b1, pos, 1'b0, e);
      chk("R5", "de continuous through frame", de_bad, 0);
      repeat (5) @(negedge clk);
   endtask

   task automatic t_back2back(input logic [7:0] d1, input logic [7:0] d2, input int div,
                              input bit pe, input bit po, input bit ts, input bit pol);
      int e1;
      int e2;
      int base;
      setup(div, pe, po, ts, pol);
      de_bad = 0;
      start_write(d1);
      base       = pos;
      sched_pos  = base + 4 * div;
      sched_data = d2;
      frame(d1, 1'b1, base, 1'b1, e1);
      frame(d2, 1'b0, e1, 1'b0, e2);
      chk("R7", "de unbroken across frames", de_bad, 0);
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      t_reset();
      t_single(8'hA5, 4, 1'b0, 1'b0, 1'b0, 1'b1);
      t_single(8'h3C, 7, 1'b1, 1'b0, 1'b1, 1'b1);
      t_single(8'h01, 5, 1'b1, 1'b1, 1'b0, 1'b0);
      t_single(8'hFF, 2, 1'b1, 1'b1, 1'b0, 1'b1);
      t_single(8'h80, 3, 1'b1, 1'b0, 1'b0, 1'b0);
      t_back2back(8'h5A, 8'hC3, 6, 1'b1, 1'b0, 1'b1, 1'b1);
      t_back2back(8'h0F, 8'hE1, 4, 1'b0, 1'b0, 1'b0, 1'b0);
      done = 1'b1;
      finish_up();
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

endmodule